// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that has been left stuck by a slave whose state machine no longer matches the master's, as happens when only the host was reset in the middle of a transfer. A single-cycle trigger starts a fixed recovery pattern on the open-drain lines. First come nine clock pulses with the data line left released, so that any slave still shifting out a byte or holding an acknowledge lets go of the data line. Next comes a start condition, and then a stop condition. After the bus-free interval the block pulses a completion flag. It then leaves both lines released.

The block drives only the two open-drain pull-down enables and watches both lines through synchronisers. Every phase length is a parameter in nanoseconds and is converted to system clocks from a clocks-per-microsecond parameter. The timer of each phase that begins by releasing a line only runs while that line reads high. This lets a slave stretch the clock, and it keeps the start setup from counting while a slave still holds the data line low. The stop follows the start with no clock edge between them, so a slave cannot treat the pattern as a write to commit.

Top module: `busclr_seq`

## Requirements
- R1: A sequence pulls SCL low exactly 9 times, and SDA is never pulled low while SCL is being pulled low.
- R2: After the 9th SCL pulse, SDA is pulled low while SCL is released. This start edge comes only after both lines have read high for at least the start-setup time (4700 ns).
- R3: SDA is then released while SCL is still released, which forms the stop. SDA stays low from start to stop for at least start hold (4000 ns) plus stop setup (4700 ns).
- R4: SCL is not pulled low at any time between the start edge and the end of the sequence.
- R5: Each SCL low phase lasts at least 4700 ns. Each SCL high phase lasts at least 4000 ns, counted from the moment SCL reads high, so a slave that holds SCL low lengthens the phase. A time of t ns equals ceil(t × CLKS_PER_US / 1000) clocks.
- R6: The completion pulse comes no earlier than 4700 ns after SDA reads high following the stop.
- R7: A trigger that arrives while a sequence is running has no effect: that sequence still gives 9 pulses and one completion, and no second sequence follows.
- R8: Busy is high from the cycle after an accepted trigger until the sequence ends. Done is high for exactly one cycle. When done is high, busy and both enables are low, and they stay low until the next trigger.
- R9: After reset, busy, done and both enables are low.
- R10: If a slave holds SDA low during the first dummy pulses, the burst still runs to 9 pulses, and the start waits until SDA reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | One-cycle trigger for a recovery sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| scl_i | input | 1 | SCL line as it reads on the bus |
| sda_i | input | 1 | SDA line as it reads on the bus |

## Verification
The bench watches the two line levels and measures every low phase, every high phase, the start setup, the span from start to stop and the bus-free interval against the required minimums. Off-by-one timer loads and high phases that are not qualified by the line both show up as phases that are too short. One slave model stretches the third clock high for 300 cycles, which catches a design that counts the high phase from its own release rather than from the line. Another holds SDA low through four dummy pulses, which catches a design that cuts the burst short or starts the setup count early. A second trigger in mid-sequence catches a design that restarts, adds pulses or emits two completions. The bench also counts every SCL pull-down after the start edge, which catches a stray clock before the stop.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CLK_LO = 3'd1,
    PH_CLK_HI = 3'd2,
    PH_STA_SU = 3'd3,
    PH_STA_HD = 3'd4,
    PH_STO_SU = 3'd5,
    PH_BUF    = 3'd6
  } phase_e;

  // nanoseconds to system clocks, rounded up, never below one clock
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clks_per_us);
    int unsigned c;
    c = (ns * clks_per_us + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..v
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/busclr_sync.sv
module busclr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] shift_q;

  // lines idle high through the pull-ups, so reset to released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '1;
    else         shift_q <= {shift_q[N-2:0], d_i};
  end

  assign q_o = shift_q[N-1];
endmodule

// File: rtl/busclr_timer.sv
module busclr_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          en_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/busclr_ctl.sv
module busclr_ctl
  import busclr_pkg::*;
#(
  parameter int unsigned CW       = 8,
  parameter int unsigned PW       = 4,
  parameter int unsigned DUMMY    = 9,
  parameter int unsigned C_LOW    = 1,
  parameter int unsigned C_HIGH   = 1,
  parameter int unsigned C_SU_STA = 1,
  parameter int unsigned C_HD_STA = 1,
  parameter int unsigned C_SU_STO = 1,
  parameter int unsigned C_BUF    = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kick_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          t_zero_i,
  output logic          t_load_o,
  output logic [CW-1:0] t_load_val_o,
  output logic          t_en_o,
  output logic [PW-1:0] pulse_cnt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  phase_e        phase_q, phase_n;
  logic [PW-1:0] pulse_q;
  logic          done_q;
  logic          step_w;

  // timer load value: a phase of d clocks loads d-1 and ends on zero
  function automatic logic [CW-1:0] dur_of(input phase_e p);
    case (p)
      PH_CLK_LO: return CW'(C_LOW - 1);
      PH_CLK_HI: return CW'(C_HIGH - 1);
      PH_STA_SU: return CW'(C_SU_STA - 1);
      PH_STA_HD: return CW'(C_HD_STA - 1);
      PH_STO_SU: return CW'(C_SU_STO - 1);
      PH_BUF:    return CW'(C_BUF - 1);
      default:   return '0;
    endcase
  endfunction

  // a phase that starts by releasing a line counts only while that line reads high
  always_comb begin
    case (phase_q)
      PH_CLK_LO: t_en_o = 1'b1;
      PH_CLK_HI: t_en_o = scl_s_i;
      PH_STA_SU: t_en_o = scl_s_i & sda_s_i;
      PH_STA_HD: t_en_o = 1'b1;
      PH_STO_SU: t_en_o = scl_s_i;
      PH_BUF:    t_en_o = scl_s_i & sda_s_i;
      default:   t_en_o = 1'b0;
    endcase
  end

  assign step_w = t_zero_i & t_en_o;

  always_comb begin
    phase_n = phase_q;
    case (phase_q)
      PH_IDLE:   if (kick_i) phase_n = PH_CLK_LO;
      PH_CLK_LO: if (step_w) phase_n = PH_CLK_HI;
      PH_CLK_HI: if (step_w) phase_n = (pulse_q == PW'(DUMMY - 1)) ? PH_STA_SU : PH_CLK_LO;
      PH_STA_SU: if (step_w) phase_n = PH_STA_HD;
      PH_STA_HD: if (step_w) phase_n = PH_STO_SU;
      PH_STO_SU: if (step_w) phase_n = PH_BUF;
      PH_BUF:    if (step_w) phase_n = PH_IDLE;
      default:   phase_n = PH_IDLE;
    endcase
  end

  assign t_load_o     = (phase_n != phase_q);
  assign t_load_val_o = dur_of(phase_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pulse_q <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      done_q  <= (phase_q == PH_BUF) && step_w;
      if (phase_q == PH_IDLE && kick_i)      pulse_q <= '0;
      else if (phase_q == PH_CLK_HI && step_w) pulse_q <= pulse_q + 1'b1;
    end
  end

  assign pulse_cnt_o = pulse_q;
  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = done_q;
  assign scl_oe_o    = (phase_q == PH_CLK_LO);
  assign sda_oe_o    = (phase_q == PH_STA_HD) || (phase_q == PH_STO_SU);
endmodule

// File: rtl/busclr_seq.sv
module busclr_seq
  import busclr_pkg::*;
#(
  parameter int unsigned CLKS_PER_US  = 100,
  parameter int unsigned DUMMY_CLOCKS = 9,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned T_LOW_NS     = 4700,
  parameter int unsigned T_HIGH_NS    = 4000,
  parameter int unsigned T_SU_STA_NS  = 4700,
  parameter int unsigned T_HD_STA_NS  = 4000,
  parameter int unsigned T_SU_STO_NS  = 4700,
  parameter int unsigned T_BUF_NS     = 4700
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o,
  output logic done_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  input  logic scl_i,
  input  logic sda_i
);
  localparam int unsigned C_LOW    = ns_to_cycles(T_LOW_NS,    CLKS_PER_US);
  localparam int unsigned C_HIGH   = ns_to_cycles(T_HIGH_NS,   CLKS_PER_US);
  localparam int unsigned C_SU_STA = ns_to_cycles(T_SU_STA_NS, CLKS_PER_US);
  localparam int unsigned C_HD_STA = ns_to_cycles(T_HD_STA_NS, CLKS_PER_US);
  localparam int unsigned C_SU_STO = ns_to_cycles(T_SU_STO_NS, CLKS_PER_US);
  localparam int unsigned C_BUF    = ns_to_cycles(T_BUF_NS,    CLKS_PER_US);
  localparam int unsigned C_MAX    = max_u(max_u(max_u(C_LOW, C_HIGH), max_u(C_SU_STA, C_HD_STA)),
                                           max_u(C_SU_STO, C_BUF));
  localparam int unsigned CW       = bits_for(C_MAX);
  localparam int unsigned PW       = bits_for(DUMMY_CLOCKS);

  // named internal events, visible to the bound checker
  logic [1:0]    line_raw_w, line_syn_w;
  logic          scl_s_w, sda_s_w;
  logic          t_load_w, t_en_w, t_zero_w;
  logic [CW-1:0] t_load_val_w;
  logic [PW-1:0] pulse_cnt_w;

  assign line_raw_w = {sda_i, scl_i};

  for (genvar i = 0; i < 2; i++) begin : g_line
    busclr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_raw_w[i]),
      .q_o    (line_syn_w[i])
    );
  end

  assign scl_s_w = line_syn_w[0];
  assign sda_s_w = line_syn_w[1];

  busclr_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load_w),
    .load_val_i (t_load_val_w),
    .en_i       (t_en_w),
    .zero_o     (t_zero_w)
  );

  busclr_ctl #(
    .CW(CW), .PW(PW), .DUMMY(DUMMY_CLOCKS),
    .C_LOW(C_LOW), .C_HIGH(C_HIGH), .C_SU_STA(C_SU_STA),
    .C_HD_STA(C_HD_STA), .C_SU_STO(C_SU_STO), .C_BUF(C_BUF)
  ) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .kick_i       (kick_i),
    .scl_s_i      (scl_s_w),
    .sda_s_i      (sda_s_w),
    .t_zero_i     (t_zero_w),
    .t_load_o     (t_load_w),
    .t_load_val_o (t_load_val_w),
    .t_en_o       (t_en_w),
    .pulse_cnt_o  (pulse_cnt_w),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o)
  );
endmodule

// File: rtl/busclr_chk.sv
module busclr_chk #(
  parameter int unsigned PW    = 4,
  parameter int unsigned DUMMY = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          kick_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          scl_oe_o,
  input logic          sda_oe_o,
  input logic [PW-1:0] pulse_cnt
);
  AST_BURST_SDA_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> !sda_oe_o); // R1
  AST_PULSE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt <= PW'(DUMMY)); // R1
  AST_START_AFTER_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> (!scl_oe_o && pulse_cnt == PW'(DUMMY))); // R2
  AST_STOP_SCL_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> (!scl_oe_o && busy_o)); // R3
  AST_NO_STRAY_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pulse_cnt == PW'(DUMMY)) |-> !scl_oe_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !scl_oe_o && !sda_oe_o)); // R8
  AST_BUSY_ON_KICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && kick_i) |=> busy_o); // R8
endmodule

bind busclr_seq busclr_chk #(.PW(PW), .DUMMY(DUMMY_CLOCKS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .kick_i    (kick_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .pulse_cnt (pulse_cnt_w)
);

// File: tb/busclr_seq_tb_top.sv
module busclr_seq_tb_top;
  localparam int CPU = 20;

  function automatic int clocks_of(input int ns);
    int q;
    q = (ns * CPU) / 1000;
    if (q * 1000 < ns * CPU) q = q + 1;
    return q;
  endfunction

  localparam int E_LOW  = clocks_of(4700);
  localparam int E_HIGH = clocks_of(4000);
  localparam int E_SU   = clocks_of(4700);
  localparam int E_HD   = clocks_of(4000);
  localparam int E_STO  = clocks_of(4700);
  localparam int E_BUF  = clocks_of(4700);

  logic clk = 1'b0, rst_n = 1'b0, kick = 1'b0;
  logic busy, done, scl_oe, sda_oe;
  logic stretch = 1'b0, hold = 1'b0;
  logic scl_line, sda_line;
  assign scl_line = !(scl_oe || stretch);
  assign sda_line = !(sda_oe || hold);

  always #2 clk = ~clk;

  busclr_seq #(.CLKS_PER_US(CPU)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .busy_o(busy), .done_o(done),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .scl_i(scl_line), .sda_i(sda_line)
  );

  int checks = 0, errors = 0, wd = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // observation state
  int n_drive, n_start, n_stop, start_at, drv_after_start, n_done;
  int done_run, max_done_run, min_low, min_high, su_sta, sda_low_len, buf_len;
  int t_scl, t_sda, both_low, sda_bad;
  bit seen_rise;
  bit stretch_on, stretch_used, hold_on;
  int stretch_left;
  logic p_scl_oe = 1'b0, p_sda_oe = 1'b0, p_scl_line = 1'b1, p_sda_line = 1'b1, p_done = 1'b0;

  task automatic clear_stats();
    n_drive = 0; n_start = 0; n_stop = 0; start_at = -1; drv_after_start = 0; n_done = 0;
    done_run = 0; max_done_run = 0; min_low = 1 << 30; min_high = 1 << 30;
    su_sta = -1; sda_low_len = -1; buf_len = -1; both_low = 0; sda_bad = 0;
    seen_rise = 0; stretch_used = 0; stretch_left = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      t_scl++; t_sda++;
      if (scl_oe && sda_oe) both_low++;
      if (scl_oe && !p_scl_oe) begin
        n_drive++;
        if (n_start > 0) drv_after_start++;
      end
      if (sda_oe && !p_sda_oe) begin
        if (scl_line) begin
          n_start++; start_at = n_drive;
          su_sta = (t_scl < t_sda) ? t_scl : t_sda;
        end else sda_bad++;
      end
      if (!sda_oe && p_sda_oe) begin
        if (scl_line) begin n_stop++; sda_low_len = t_sda; end
        else sda_bad++;
      end
      if (done) begin
        done_run++;
        if (done_run > max_done_run) max_done_run = done_run;
        if (!p_done) begin n_done++; buf_len = t_sda; end
      end else done_run = 0;
      if (scl_line != p_scl_line) begin
        if (!scl_line) begin
          if (seen_rise && t_scl < min_high) min_high = t_scl;
        end else begin
          if (t_scl < min_low) min_low = t_scl;
          seen_rise = 1;
        end
        t_scl = 0;
      end
      if (sda_line != p_sda_line) t_sda = 0;
    end
    p_scl_oe = scl_oe; p_sda_oe = sda_oe; p_scl_line = scl_line;
    p_sda_line = sda_line; p_done = done;
    // slave models: clock stretch on the third pulse, SDA held through four pulses
    if (stretch_on && n_drive == 3 && scl_oe && !stretch_used) begin
      stretch = 1'b1; stretch_used = 1; stretch_left = 300;
    end else if (stretch && !scl_oe) begin
      if (stretch_left == 0) stretch = 1'b0;
      else stretch_left--;
    end
    hold = hold_on && (n_drive < 5);
  end

  task automatic run_seq(input string name, input bit mid_kick, input bit do_stretch,
                         input bit do_hold);
    int cyc;
    clear_stats();
    stretch_on = do_stretch; hold_on = do_hold;
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    check(busy === 1'b1, {name, " R8 busy after kick"}, busy, 1);
    cyc = 0;
    while (n_done == 0 && cyc < 20000) begin
      @(negedge clk); cyc++;
      kick = (mid_kick && (cyc == 100 || cyc == 700 || cyc == 1500)) ? 1'b1 : 1'b0;
    end
    kick = 1'b0;
    check(n_done == 1, {name, " R8 completion seen"}, n_done, 1);
    repeat (30) @(negedge clk);
    check(n_drive == 9, {name, " R1 SCL pulse count"}, n_drive, 9);
    check(both_low == 0, {name, " R1 SDA low while SCL pulled"}, both_low, 0);
    check(n_start == 1 && start_at == 9, {name, " R2 start after 9th pulse"}, start_at, 9);
    check(su_sta >= E_SU, {name, " R2 start setup"}, su_sta, E_SU);
    check(n_stop == 1, {name, " R3 one stop"}, n_stop, 1);
    check(sda_low_len >= E_HD + E_STO, {name, " R3 start-to-stop span"}, sda_low_len, E_HD + E_STO);
    check(drv_after_start == 0, {name, " R4 stray SCL after start"}, drv_after_start, 0);
    check(min_low >= E_LOW, {name, " R5 SCL low time"}, min_low, E_LOW);
    check(min_high >= E_HIGH, {name, " R5 SCL high time"}, min_high, E_HIGH);
    check(buf_len >= E_BUF, {name, " R6 bus free before done"}, buf_len, E_BUF);
    check(max_done_run == 1, {name, " R8 done width"}, max_done_run, 1);
    check(n_done == 1, {name, " R7 single completion"}, n_done, 1);
    check(!busy && !scl_oe && !sda_oe, {name, " R8 released after done"},
          {busy, scl_oe, sda_oe}, 0);
    check(sda_bad == 0, {name, " R10 SDA edges only as start/stop"}, sda_bad, 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog R8 actual %0d expected below 150000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_stats();
    stretch_on = 0; hold_on = 0;
    t_scl = 0; t_sda = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !done && !scl_oe && !sda_oe, "R9 reset state",
          {busy, done, scl_oe, sda_oe}, 0);
    run_seq("plain", 0, 0, 0);
    run_seq("kick-while-busy R7", 1, 0, 0);
    check(busy === 1'b0, "R7 no second sequence", busy, 0);
    run_seq("stretch R5", 0, 1, 0);
    run_seq("sda-held R10", 0, 0, 1);
    run_seq("back-to-back", 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule